// File: doc/BRIEF.md
# Optical Pickup Servo Sequencer

This block runs a whole pickup movement on its own once the host has issued a single command. The command names one of five fixed recipes: focus acquisition, a single-track hop, a ten-track hop, a hop of N tracks with a settling phase, or a sled-only traverse of N tracks. Any track or sled recipe can run toward the inside or the outside of the disc. While the recipe runs, the block sets the mode codes of the focus, track and sled servo amplifiers. It follows the focus-lock, focus-zero-cross and track-crossing pulse inputs, and it times each pause from one of five host-set wait values.

Waits are counted in ticks of a shared time base that fires once every `PRESCALE` clock cycles. The three sensor inputs pass through two-stage synchronisers before use. `busy` shows when a recipe is running. A new valid command issued while `busy` is high cancels the current recipe: every servo output goes to off for one cycle, and then the new recipe starts. All pins are plain levels or single-cycle strobes. Nothing in the block stalls, so there is no back-pressure.

Top module: `servo_seq_top`

## Requirements
- R1: After reset `focus_mode`, `track_mode` and `sled_mode` are 0 (off) and `busy` is 0.
- R2: A `cmd_strobe` with `cmd_op` in 1..5 (1 focus, 2 single hop, 3 ten-track hop, 4 N-track hop, 5 N-track sled move) makes `busy` 1 on the next cycle and leaves the servo outputs unchanged on that cycle. The first-phase outputs appear one cycle later.
- R3: A strobe with `cmd_op` of 0, 6 or 7 is ignored: `busy` and all servo outputs keep their values.
- R4: Focus recipe: `focus_mode` is 2 (search up) until `focus_ok` is seen high. `fzc` must then stay high for E ticks, and any low sample restarts that count. After this the block waits for `fzc` to go low, then sets `focus_mode` to 1 (on) and drops `busy`.
- R5: Single hop: track 2 (forward kick) and sled 0. After blind time A, the first rising edge of `cnin` switches track to 3 (reverse kick) for B ticks. After that, track and sled are both 1.
- R6: Ten-track hop: track and sled are both 2. After A, five `cnin` rising edges switch track to 3. Track stays at 3 until C ticks pass with no `cnin` rising edge, and then track and sled are both 1.
- R7: N-track hop: the same as R6 but with N edges. After the overflow, track goes to 1 while sled keeps kicking for D ticks, and then sled goes to 1.
- R8: N-track move: track 0 and sled 2. After A and N edges, both go to 0. A count field of 0 means 65536 edges.
- R9: With `cmd_rev` high, every kick code in R5-R8 is swapped (2 becomes 3 and 3 becomes 2).
- R10: `cnin` edges that arrive during blind time A are not counted.
- R11: A valid strobe while `busy` is high forces all three servo outputs to 0 on the next cycle while `busy` stays 1. The new recipe's first phase follows one cycle later.
- R12: A wait value v lasts v ticks, and v = 0 lasts one tick.
- R13: Track recipes leave `focus_mode` untouched, and the focus recipe leaves track and sled untouched. While `busy` is 0, no output holds a kick or search code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cmd_strobe | input | 1 | one-cycle command strobe |
| cmd_op | input | 3 | recipe select |
| cmd_rev | input | 1 | reverse direction |
| cmd_count | input | N_W | track count N (0 = 65536) |
| wait_a | input | WAIT_W | blind time, ticks |
| wait_b | input | WAIT_W | brake time, ticks |
| wait_c | input | WAIT_W | crossing-period overflow, ticks |
| wait_d | input | WAIT_W | sled settle time, ticks |
| wait_e | input | WAIT_W | zero-cross hold time, ticks |
| focus_ok | input | 1 | focus lock detected |
| fzc | input | 1 | focus zero-cross level |
| cnin | input | 1 | track crossing pulse |
| focus_mode | output | 2 | 0 off, 1 on, 2 search up |
| track_mode | output | 2 | 0 off, 1 on, 2 fwd kick, 3 rev kick |
| sled_mode | output | 2 | same coding as track |
| busy | output | 1 | recipe running |

## Verification
The bench pulses `cnin` during the blind window. A design that counts those pulses brakes early and fails the R10 probe. The bench also drops `fzc` briefly while focus is held, and then drops it again before a full E window has passed. A design that does not restart the hold count would turn focus on at that point. To show that each recipe waits for its count, the bench checks that the brake has not started after N−1 crossings. It also checks that sled kicking continues while track is already on during the N-hop settle phase. Finally, it cancels a running recipe and checks that the outputs go to off for exactly one cycle before the new recipe appears, which shows both a missed cancel and a skipped off cycle.

// File: rtl/servo_seq_pkg.sv
package servo_seq_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_FOCUS = 3'd1, OP_HOP1 = 3'd2,
    OP_HOP10 = 3'd3, OP_HOPN = 3'd4, OP_MOVEN = 3'd5
  } op_e;

  typedef enum logic [1:0] {AX_OFF = 2'd0, AX_ON = 2'd1, AX_KFWD = 2'd2, AX_KREV = 2'd3} axis_e;
  typedef enum logic [1:0] {FC_OFF = 2'd0, FC_ON = 2'd1, FC_SEARCH = 2'd2} focus_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LAUNCH, S_F_SEEK, S_F_HOLD, S_F_FALL,
    S_J_BLIND, S_J_COUNT, S_J_BRAKE, S_J_OVF, S_J_SETTLE
  } state_e;

  typedef enum logic [2:0] {T_A, T_B, T_C, T_D, T_E} tsel_e;

  function automatic logic op_valid(input logic [2:0] op);
    return (op >= 3'd1) && (op <= 3'd5);
  endfunction
endpackage

// File: rtl/servo_seq_tick.sv
module servo_seq_tick #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] div;

  assign tick = (div == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div <= '0;
    else if (tick) div <= '0;
    else           div <= div + PW'(1);
  end
endmodule

// File: rtl/servo_seq_timer.sv
module servo_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start,
  input  logic [W-1:0] len,
  output logic         expired
);
  localparam int CW = W + 1;

  logic [W-1:0]  len_q;
  logic [W-1:0]  cnt;
  logic          run;
  logic [CW-1:0] eff;
  logic [CW-1:0] nxt;

  assign eff = (len_q == '0) ? CW'(1) : {1'b0, len_q};
  assign nxt = {1'b0, cnt} + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      cnt     <= '0;
      run     <= 1'b0;
      expired <= 1'b0;
    end else if (start) begin
      len_q   <= len;
      cnt     <= '0;
      run     <= 1'b1;
      expired <= 1'b0;
    end else if (run && tick) begin
      if (nxt >= eff) begin
        run     <= 1'b0;
        expired <= 1'b1;
      end else begin
        cnt <= nxt[W-1:0];
      end
    end
  end
endmodule

// File: rtl/servo_seq_sense.sv
module servo_seq_sense #(
  parameter int SYNC = 2,
  parameter int CW   = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    raw,
  input  logic          clr,
  output logic [2:0]    lvl,
  output logic          rise,
  output logic [CW-1:0] cnt
);
  logic cnin_q;

  for (genvar b = 0; b < 3; b++) begin : g_sync
    logic [SYNC-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC-2:0], raw[b]};
    end
    assign lvl[b] = chain[SYNC-1];
  end

  assign rise = lvl[2] & ~cnin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnin_q <= 1'b0;
      cnt    <= '0;
    end else begin
      cnin_q <= lvl[2];
      if (clr)       cnt <= '0;
      else if (rise) cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/servo_seq_top.sv
module servo_seq_top
  import servo_seq_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int WAIT_W   = 8,
  parameter int N_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_strobe,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_rev,
  input  logic [N_W-1:0]    cmd_count,
  input  logic [WAIT_W-1:0] wait_a,
  input  logic [WAIT_W-1:0] wait_b,
  input  logic [WAIT_W-1:0] wait_c,
  input  logic [WAIT_W-1:0] wait_d,
  input  logic [WAIT_W-1:0] wait_e,
  input  logic              focus_ok,
  input  logic              fzc,
  input  logic              cnin,
  output logic [1:0]        focus_mode,
  output logic [1:0]        track_mode,
  output logic [1:0]        sled_mode,
  output logic              busy
);
  localparam int CW = N_W + 1;

  state_e   state, state_n;
  op_e      op_q;
  logic     rev_q;
  logic [N_W-1:0] n_q;
  focus_e   foc_r, foc_n;
  axis_e    trk_r, trk_n, sld_r, sld_n;
  logic     busy_r, busy_n;

  logic              tick;
  logic              tmr_start, tmr_exp;
  tsel_e             tmr_sel;
  logic [WAIT_W-1:0] tmr_len;
  logic [2:0]        lvl;
  logic              rise;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     target;
  axis_e             kf, kr;
  logic              op_ok;

  servo_seq_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  always_comb begin
    case (tmr_sel)
      T_A:     tmr_len = wait_a;
      T_B:     tmr_len = wait_b;
      T_C:     tmr_len = wait_c;
      T_D:     tmr_len = wait_d;
      default: tmr_len = wait_e;
    endcase
  end

  servo_seq_timer #(.W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(tmr_start),
    .len(tmr_len), .expired(tmr_exp)
  );

  servo_seq_sense #(.SYNC(2), .CW(CW)) u_sense (
    .clk(clk), .rst_n(rst_n), .raw({cnin, fzc, focus_ok}),
    .clr(state != S_J_COUNT), .lvl(lvl), .rise(rise), .cnt(cnt)
  );

  assign op_ok = op_valid(cmd_op);
  assign kf    = rev_q ? AX_KREV : AX_KFWD;
  assign kr    = rev_q ? AX_KFWD : AX_KREV;

  always_comb begin
    case (op_q)
      OP_HOP1:  target = CW'(1);
      OP_HOP10: target = CW'(5);
      default:  target = (n_q == '0) ? {1'b1, {N_W{1'b0}}} : {1'b0, n_q};
    endcase
  end

  always_comb begin
    state_n   = state;
    foc_n     = foc_r;
    trk_n     = trk_r;
    sld_n     = sld_r;
    busy_n    = busy_r;
    tmr_start = 1'b0;
    tmr_sel   = T_A;
    case (state)
      S_LAUNCH: begin
        case (op_q)
          OP_FOCUS: begin foc_n = FC_SEARCH; state_n = S_F_SEEK; end
          OP_HOP1: begin
            trk_n = kf; sld_n = AX_OFF; tmr_start = 1'b1; state_n = S_J_BLIND;
          end
          OP_HOP10, OP_HOPN: begin
            trk_n = kf; sld_n = kf; tmr_start = 1'b1; state_n = S_J_BLIND;
          end
          OP_MOVEN: begin
            trk_n = AX_OFF; sld_n = kf; tmr_start = 1'b1; state_n = S_J_BLIND;
          end
          default: begin state_n = S_IDLE; busy_n = 1'b0; end
        endcase
      end
      S_F_SEEK: if (lvl[0]) begin
        tmr_start = 1'b1; tmr_sel = T_E; state_n = S_F_HOLD;
      end
      S_F_HOLD: begin
        if (!lvl[1]) begin
          tmr_start = 1'b1; tmr_sel = T_E;
        end else if (tmr_exp) begin
          state_n = S_F_FALL;
        end
      end
      S_F_FALL: if (!lvl[1]) begin
        foc_n = FC_ON; state_n = S_IDLE; busy_n = 1'b0;
      end
      S_J_BLIND: if (tmr_exp) state_n = S_J_COUNT;
      S_J_COUNT: if (cnt >= target) begin
        case (op_q)
          OP_HOP1: begin
            trk_n = kr; tmr_start = 1'b1; tmr_sel = T_B; state_n = S_J_BRAKE;
          end
          OP_HOP10, OP_HOPN: begin
            trk_n = kr; tmr_start = 1'b1; tmr_sel = T_C; state_n = S_J_OVF;
          end
          default: begin
            trk_n = AX_OFF; sld_n = AX_OFF; state_n = S_IDLE; busy_n = 1'b0;
          end
        endcase
      end
      S_J_BRAKE: if (tmr_exp) begin
        trk_n = AX_ON; sld_n = AX_ON; state_n = S_IDLE; busy_n = 1'b0;
      end
      S_J_OVF: begin
        if (rise) begin
          tmr_start = 1'b1; tmr_sel = T_C;
        end else if (tmr_exp) begin
          trk_n = AX_ON;
          if (op_q == OP_HOPN) begin
            tmr_start = 1'b1; tmr_sel = T_D; state_n = S_J_SETTLE;
          end else begin
            sld_n = AX_ON; state_n = S_IDLE; busy_n = 1'b0;
          end
        end
      end
      S_J_SETTLE: if (tmr_exp) begin
        sld_n = AX_ON; state_n = S_IDLE; busy_n = 1'b0;
      end
      default: ;
    endcase

    if (cmd_strobe && op_ok) begin
      state_n   = S_LAUNCH;
      busy_n    = 1'b1;
      tmr_start = 1'b0;
      if (busy_r) begin
        foc_n = FC_OFF; trk_n = AX_OFF; sld_n = AX_OFF;
      end else begin
        foc_n = foc_r; trk_n = trk_r; sld_n = sld_r;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      foc_r  <= FC_OFF;
      trk_r  <= AX_OFF;
      sld_r  <= AX_OFF;
      busy_r <= 1'b0;
      op_q   <= OP_NONE;
      rev_q  <= 1'b0;
      n_q    <= '0;
    end else begin
      state  <= state_n;
      foc_r  <= foc_n;
      trk_r  <= trk_n;
      sld_r  <= sld_n;
      busy_r <= busy_n;
      if (cmd_strobe && op_ok) begin
        op_q  <= op_e'(cmd_op);
        rev_q <= cmd_rev;
        n_q   <= cmd_count;
      end
    end
  end

  assign focus_mode = foc_r;
  assign track_mode = trk_r;
  assign sled_mode  = sld_r;
  assign busy       = busy_r;
endmodule

// File: rtl/servo_seq_chk.sv
module servo_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_strobe,
  input logic [2:0] cmd_op,
  input logic [1:0] focus_mode,
  input logic [1:0] track_mode,
  input logic [1:0] sled_mode,
  input logic       busy
);
  logic good_op;
  assign good_op = (cmd_op >= 3'd1) && (cmd_op <= 3'd5);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && good_op && !busy) |=> busy);

  // R3
  bad_op_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && !good_op && !busy) |=> !busy);

  // R11
  abort_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && good_op && busy) |=>
      (busy && focus_mode == 2'd0 && track_mode == 2'd0 && sled_mode == 2'd0));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (track_mode[1] == 1'b0 && sled_mode[1] == 1'b0 && focus_mode != 2'd2));

  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_strobe));
endmodule

bind servo_seq_top servo_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_op(cmd_op),
  .focus_mode(focus_mode), .track_mode(track_mode), .sled_mode(sled_mode),
  .busy(busy)
);

// File: tb/tb_servo_seq_top.sv
module tb_servo_seq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_strobe = 1'b0;
  logic [2:0] cmd_op = '0;
  logic cmd_rev = 1'b0;
  logic [15:0] cmd_count = '0;
  logic [7:0] wait_a = 8'd2, wait_b = 8'd4, wait_c = 8'd8, wait_d = 8'd8, wait_e = 8'd4;
  logic focus_ok = 1'b0, fzc = 1'b0, cnin = 1'b0;
  logic [1:0] focus_mode, track_mode, sled_mode;
  logic busy;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  servo_seq_top dut (.*);

  typedef struct packed {
    logic [2:0] op; logic rev; logic [15:0] n; logic [7:0] tgt;
    logic [1:0] it, is, mt, ms, ft, fs;
  } vec_t;

  // track/sled codes: 0 off, 1 on, 2 fwd kick, 3 rev kick
  localparam vec_t VECS [8] = '{
    '{3'd2, 1'b0, 16'd0, 8'd1, 2'd2, 2'd0, 2'd3, 2'd0, 2'd1, 2'd1},
    '{3'd2, 1'b1, 16'd0, 8'd1, 2'd3, 2'd0, 2'd2, 2'd0, 2'd1, 2'd1},
    '{3'd3, 1'b0, 16'd0, 8'd5, 2'd2, 2'd2, 2'd3, 2'd2, 2'd1, 2'd1},
    '{3'd3, 1'b1, 16'd0, 8'd5, 2'd3, 2'd3, 2'd2, 2'd3, 2'd1, 2'd1},
    '{3'd4, 1'b0, 16'd3, 8'd3, 2'd2, 2'd2, 2'd3, 2'd2, 2'd1, 2'd1},
    '{3'd4, 1'b1, 16'd2, 8'd2, 2'd3, 2'd3, 2'd2, 2'd3, 2'd1, 2'd1},
    '{3'd5, 1'b0, 16'd4, 8'd4, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0},
    '{3'd5, 1'b1, 16'd1, 8'd1, 2'd0, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string rq(input logic [2:0] op, input logic rev);
    if (rev) return "R9";
    case (op)
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic strobe(input logic [2:0] op, input logic rev, input logic [15:0] n);
    @(negedge clk);
    cmd_strobe = 1'b1; cmd_op = op; cmd_rev = rev; cmd_count = n;
    @(negedge clk);
    cmd_strobe = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); cnin = 1'b1;
    repeat (4) @(negedge clk);
    cnin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim && busy; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "focus", focus_mode, 0);
    chk("R1", "track", track_mode, 0);
    chk("R1", "sled", sled_mode, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 invalid opcode ignored
    strobe(3'd6, 1'b0, 16'd0);
    chk("R3", "busy", busy, 0);
    repeat (4) @(negedge clk);
    chk("R3", "busy later", busy, 0);
    chk("R3", "track", track_mode, 0);

    // R4 focus recipe with zero-cross glitch
    strobe(3'd1, 1'b0, 16'd0);
    chk("R2", "busy after strobe", busy, 1);
    chk("R2", "focus unchanged", focus_mode, 0);
    @(negedge clk);
    chk("R4", "search", focus_mode, 2);
    fzc = 1'b1;
    repeat (30) @(negedge clk);
    fzc = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4", "waits focus_ok", focus_mode, 2);
    focus_ok = 1'b1; fzc = 1'b1;
    repeat (8) @(negedge clk);
    fzc = 1'b0;
    repeat (2) @(negedge clk);
    fzc = 1'b1;
    repeat (10) @(negedge clk);
    fzc = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4", "hold restarted", focus_mode, 2);
    chk("R4", "busy in hold", busy, 1);
    fzc = 1'b1;
    repeat (40) @(negedge clk);
    chk("R4", "waits fzc low", busy, 1);
    fzc = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4", "focus on", focus_mode, 1);
    chk("R4", "done", busy, 0);
    chk("R13", "track untouched", track_mode, 0);
    focus_ok = 1'b0;

    // table of track recipes
    foreach (VECS[k]) begin
      strobe(VECS[k].op, VECS[k].rev, VECS[k].n);
      chk("R2", "busy", busy, 1);
      @(negedge clk);
      chk(rq(VECS[k].op, VECS[k].rev), "first track", track_mode, VECS[k].it);
      chk(rq(VECS[k].op, VECS[k].rev), "first sled", sled_mode, VECS[k].is);
      repeat (24) @(negedge clk);
      for (int p = 1; p < int'(VECS[k].tgt); p++) pulse();
      chk(rq(VECS[k].op, VECS[k].rev), "before last edge", track_mode, VECS[k].it);
      pulse();
      chk(rq(VECS[k].op, VECS[k].rev), "after count track", track_mode, VECS[k].mt);
      chk(rq(VECS[k].op, VECS[k].rev), "after count sled", sled_mode, VECS[k].ms);
      wait_idle(400);
      chk(rq(VECS[k].op, VECS[k].rev), "end track", track_mode, VECS[k].ft);
      chk(rq(VECS[k].op, VECS[k].rev), "end sled", sled_mode, VECS[k].fs);
      chk("R13", "focus kept", focus_mode, 1);
    end

    // R7 settle: track on while sled still kicks
    strobe(3'd4, 1'b0, 16'd2);
    repeat (25) @(negedge clk);
    pulse(); pulse();
    for (int i = 0; i < 200 && track_mode != 2'd1; i++) @(negedge clk);
    @(negedge clk);
    chk("R7", "settle sled kick", sled_mode, 2);
    chk("R7", "settle busy", busy, 1);
    wait_idle(200);
    chk("R7", "sled on", sled_mode, 1);

    // R10 edges in blind window ignored
    wait_a = 8'd10;
    strobe(3'd2, 1'b0, 16'd0);
    pulse();
    repeat (45) @(negedge clk);
    chk("R10", "no brake from blind edge", track_mode, 2);
    pulse();
    chk("R10", "brake after real edge", track_mode, 3);
    wait_idle(200);

    // R12 zero wait is one tick
    wait_a = 8'd0;
    strobe(3'd2, 1'b0, 16'd0);
    repeat (6) @(negedge clk);
    pulse();
    chk("R12", "zero blind brake", track_mode, 3);
    wait_idle(200);
    wait_a = 8'd2;

    // R11 abort
    strobe(3'd3, 1'b0, 16'd0);
    repeat (3) @(negedge clk);
    strobe(3'd2, 1'b1, 16'd0);
    chk("R11", "focus off", focus_mode, 0);
    chk("R11", "track off", track_mode, 0);
    chk("R11", "sled off", sled_mode, 0);
    chk("R11", "busy", busy, 1);
    @(negedge clk);
    chk("R11", "new track", track_mode, 3);
    chk("R11", "new sled", sled_mode, 0);
    repeat (24) @(negedge clk);
    pulse();
    wait_idle(200);
    chk("R11", "new done", track_mode, 1);

    summary();
  end
endmodule